// File: doc/BRIEF.md
# Hash Engine Operation Sequencer

This block is the control and context front end of a block-based hash accelerator. Software writes the context through a 32-bit register bus: eight initial-digest words, a byte count, a mode word and a length. The block keeps the processed-byte count and the remaining length. It then runs the phases of the job in order: optional HMAC key processing, the 64-byte message blocks, a final padded block and an optional outer hash.

The compression rounds are not part of this block. Each block of work is handed to an external core with a one-cycle request that carries a phase code. The core answers with a done pulse some fixed number of cycles later. The algorithm select goes straight to the core.

A write to the length register is the start trigger. The mode bits clear themselves as their phases complete, so a read of the mode register after a job shows which work is still pending.

Top module: `hash_seq`

## Requirements
- R1: Register word addresses are 0 to 7 for digest words, 8 for the byte count, 9 for the mode and 10 for the remaining length. The mode word holds outer-hash at bit 7, key-processing at bit 5, close at bit 4 and use-constants at bit 3. Bits 2:1 select the algorithm (0 MD5, 1 SHA-1, 2 SHA-224, 3 SHA-256) and also drive `algo`. All other mode bits read 0.
- R2: A length write while idle starts a job: `busy` is high from the next cycle until the last phase completes. A start that has no work drops `busy` again without any request.
- R3: Byte-count writes ignore bits 5:0. After a job the count reads the initial value plus the bytes processed, modulo 2^LEN_W.
- R4: With use-constants set, the start loads the digest words with the selected algorithm's initial values and forces the count to 0. The initial values are word 0 = 67452301 for MD5 and SHA-1, word 0 = 6a09e667 and word 7 = 5be0cd19 for SHA-256, and word 4 = c3d2e1f0 for SHA-1; unused words are 0. The bit clears after the first block.
- R5: With key-processing set, the start forces the count to 64. Two blocks run, with phases 1 and 2, and the key bit then clears.
- R6: While the remaining length is at least 64, data blocks run with phase 3, and each lowers the length by 64 and raises the count by 64. If close is set, one final block then runs with phase 4. It adds the residual length to the count, zeroes the length and clears the close bit.
- R7: With outer-hash set, a block with phase 5 runs after the other phases, or alone when the length is 0, and the outer bit then clears.
- R8: A length whose bits 5:0 are not zero while close is clear sets the sticky `cfg_err`. No job starts and the length register keeps its value.
- R9: Register writes while `busy` is high have no effect.
- R10: `blk_req` is a one-cycle pulse with the phase on `blk_phase`. No new request is issued before `blk_done` for the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 32 | Read data (combinational) |
| blk_req | output | 1 | Block request pulse to the compression core |
| blk_phase | output | 3 | Phase of the requested block |
| algo | output | 2 | Algorithm select to the core |
| blk_done | input | 1 | Core has finished the requested block |
| busy | output | 1 | Job in progress |
| cfg_err | output | 1 | Sticky length/mode error |

## Verification
The bench builds the block with LEN_W = 12, so the byte count and length registers are 12 bits wide. A count preloaded near 4032 therefore wraps to zero after a single block, which brings the modulo behaviour of the count within reach of a short run. The compression core is modelled with a four-cycle latency. That latency leaves room for register writes to land inside a running job, which exercises the rule that writes while busy are ignored.

// File: rtl/hash_seq.sv
module hash_seq #(
  parameter int LEN_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [3:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        blk_req,
  output logic [2:0]  blk_phase,
  output logic [1:0]  algo,
  input  logic        blk_done,
  output logic        busy,
  output logic        cfg_err
);
  localparam int BLK = 64;
  localparam int OFS = $clog2(BLK);

  typedef enum logic [1:0] {S_IDLE, S_PICK, S_WAIT} st_t;
  typedef enum logic [2:0] {P_NONE, P_KI, P_KO, P_DATA, P_FIN, P_OUT} ph_t;

  st_t              st;
  ph_t              ph, nxt;
  logic [7:0][31:0] dig;
  logic [LEN_W-1:0] cnt, rem;
  logic             m_outer, m_key, m_close, m_const, kstep, req_q, err_q;
  logic [1:0]       m_alg;

  function automatic logic [31:0] iv(input logic [1:0] a, input logic [2:0] i);
    case ({a, i})
      {2'd0, 3'd0}, {2'd1, 3'd0}: iv = 32'h67452301;
      {2'd0, 3'd1}, {2'd1, 3'd1}: iv = 32'hefcdab89;
      {2'd0, 3'd2}, {2'd1, 3'd2}: iv = 32'h98badcfe;
      {2'd0, 3'd3}, {2'd1, 3'd3}: iv = 32'h10325476;
      {2'd1, 3'd4}: iv = 32'hc3d2e1f0;
      {2'd2, 3'd0}: iv = 32'hc1059ed8;
      {2'd2, 3'd1}: iv = 32'h367cd507;
      {2'd2, 3'd2}: iv = 32'h3070dd17;
      {2'd2, 3'd3}: iv = 32'hf70e5939;
      {2'd2, 3'd4}: iv = 32'hffc00b31;
      {2'd2, 3'd5}: iv = 32'h68581511;
      {2'd2, 3'd6}: iv = 32'h64f98fa7;
      {2'd2, 3'd7}: iv = 32'hbefa4fa4;
      {2'd3, 3'd0}: iv = 32'h6a09e667;
      {2'd3, 3'd1}: iv = 32'hbb67ae85;
      {2'd3, 3'd2}: iv = 32'h3c6ef372;
      {2'd3, 3'd3}: iv = 32'ha54ff53a;
      {2'd3, 3'd4}: iv = 32'h510e527f;
      {2'd3, 3'd5}: iv = 32'h9b05688c;
      {2'd3, 3'd6}: iv = 32'h1f83d9ab;
      {2'd3, 3'd7}: iv = 32'h5be0cd19;
      default:      iv = 32'h0;
    endcase
  endfunction

  assign busy      = (st != S_IDLE);
  assign blk_req   = req_q;
  assign blk_phase = ph;
  assign algo      = m_alg;
  assign cfg_err   = err_q;

  always_comb begin
    if (m_key)            nxt = kstep ? P_KO : P_KI;
    else if (rem >= BLK)  nxt = P_DATA;
    else if (m_close)     nxt = P_FIN;
    else if (m_outer)     nxt = P_OUT;
    else                  nxt = P_NONE;
  end

  always_comb begin
    if (rd_addr < 4'd8)        rd_data = dig[rd_addr[2:0]];
    else if (rd_addr == 4'd8)  rd_data = 32'(cnt);
    else if (rd_addr == 4'd9)  rd_data = {24'b0, m_outer, 1'b0, m_key, m_close, m_const, m_alg, 1'b0};
    else if (rd_addr == 4'd10) rd_data = 32'(rem);
    else                       rd_data = 32'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= P_NONE; dig <= '0; cnt <= '0; rem <= '0;
      m_outer <= 1'b0; m_key <= 1'b0; m_close <= 1'b0; m_const <= 1'b0;
      m_alg <= 2'd0; kstep <= 1'b0; req_q <= 1'b0; err_q <= 1'b0;
    end else begin
      req_q <= 1'b0;
      case (st)
        S_IDLE: if (wr_en) begin
          if (wr_addr < 4'd8) dig[wr_addr[2:0]] <= wr_data;
          else if (wr_addr == 4'd8) cnt <= {wr_data[LEN_W-1:OFS], {OFS{1'b0}}};
          else if (wr_addr == 4'd9) begin
            m_outer <= wr_data[7]; m_key <= wr_data[5]; m_close <= wr_data[4];
            m_const <= wr_data[3]; m_alg <= wr_data[2:1];
          end else if (wr_addr == 4'd10) begin
            if (!m_close && wr_data[OFS-1:0] != '0) err_q <= 1'b1;
            else begin
              rem   <= wr_data[LEN_W-1:0];
              kstep <= 1'b0;
              st    <= S_PICK;
              if (m_key) cnt <= LEN_W'(BLK);
              else if (m_const) begin
                cnt <= '0;
                for (int i = 0; i < 8; i++) dig[i] <= iv(m_alg, 3'(i));
              end
            end
          end
        end
        S_PICK: begin
          ph <= nxt;
          if (nxt == P_NONE) st <= S_IDLE;
          else begin
            req_q <= 1'b1;
            st    <= S_WAIT;
          end
        end
        S_WAIT: if (blk_done) begin
          st      <= S_PICK;
          m_const <= 1'b0;
          case (ph)
            P_KI:   kstep <= 1'b1;
            P_KO:   begin kstep <= 1'b0; m_key <= 1'b0; end
            P_DATA: begin rem <= rem - LEN_W'(BLK); cnt <= cnt + LEN_W'(BLK); end
            P_FIN:  begin cnt <= cnt + rem; rem <= '0; m_close <= 1'b0; end
            P_OUT:  m_outer <= 1'b0;
            default: ;
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(dig));
  // R10
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) blk_req |=> !blk_req);
  // R6
  rem_down_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |=> rem <= $past(rem));
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) cfg_err |=> cfg_err);
  // R5
  key_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(m_key) && $past(busy)) |-> ($past(blk_phase) == 3'd2));
endmodule

// File: tb/sim_hash_seq.sv
module sim_hash_seq;
  localparam int LW  = 12;
  localparam int LAT = 4;

  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, blk_done = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic        blk_req, busy, cfg_err;
  logic [2:0]  blk_phase;
  logic [1:0]  algo;

  int n_chk = 0, n_fail = 0;
  logic [2:0] exp_q[$];
  logic finished = 1'b0;

  hash_seq #(.LEN_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .blk_req(blk_req), .blk_phase(blk_phase),
    .algo(algo), .blk_done(blk_done), .busy(busy), .cfg_err(cfg_err));

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic expect_reg(input logic [3:0] a, input logic [31:0] e, input string tag);
    logic [31:0] v;
    rd(a, v);
    check(v == e, tag, v, e);
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
    check(!busy, tag, 32'(busy), 32'h0);
    check(exp_q.size() == 0, tag, 32'(exp_q.size()), 32'h0);
  endtask

  // compression core model
  initial forever begin
    @(negedge clk);
    if (blk_req) begin
      repeat (LAT - 1) @(negedge clk);
      blk_done = 1'b1;
      @(negedge clk);
      blk_done = 1'b0;
    end
  end

  // monitor
  initial forever begin
    @(negedge clk);
    if (blk_req) begin
      if (exp_q.size() == 0) check(1'b0, "R10 unexpected request", 32'(blk_phase), 32'h0);
      else begin
        logic [2:0] e;
        e = exp_q.pop_front();
        check(blk_phase == e, "R10 phase order", 32'(blk_phase), 32'(e));
      end
    end
  end

  initial begin
    #4000000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(!busy && !cfg_err && !blk_req, "R2 reset outputs", {busy, cfg_err, blk_req}, 32'h0);
    expect_reg(4'd9, 32'h0, "R1 reset mode");
    expect_reg(4'd8, 32'h0, "R3 reset count");

    // R1 mode fields
    wr(4'd9, 32'hFF);
    expect_reg(4'd9, 32'hBE, "R1 mode readback");
    check(algo == 2'd3, "R1 algo out", 32'(algo), 32'd3);
    wr(4'd9, 32'h0);

    // R4 + R6 SHA-256 constants, close, 128 bytes
    wr(4'd9, 32'h1E);
    exp_q.push_back(3'd3); exp_q.push_back(3'd3); exp_q.push_back(3'd4);
    wr(4'd10, 32'd128);
    check(busy, "R2 busy after start", 32'(busy), 32'h1);
    expect_reg(4'd0, 32'h6a09e667, "R4 sha256 word0");
    expect_reg(4'd7, 32'h5be0cd19, "R4 sha256 word7");
    wait_idle("R6 sha256 job");
    expect_reg(4'd8, 32'd128, "R6 count 128");
    expect_reg(4'd10, 32'd0, "R6 length zero");
    expect_reg(4'd9, 32'h06, "R4 R6 bits cleared");

    // R6 residual with MD5 constants
    wr(4'd9, 32'h18);
    exp_q.push_back(3'd3); exp_q.push_back(3'd4);
    wr(4'd10, 32'd100);
    wait_idle("R6 residual job");
    expect_reg(4'd8, 32'd100, "R6 residual count");
    expect_reg(4'd0, 32'h67452301, "R4 md5 word0");
    expect_reg(4'd4, 32'h0, "R4 md5 word4");

    // R3 continue without close
    wr(4'd9, 32'h0);
    wr(4'd8, 32'h205);
    expect_reg(4'd8, 32'h200, "R3 low bits dropped");
    exp_q.push_back(3'd3); exp_q.push_back(3'd3);
    wr(4'd10, 32'd128);
    wait_idle("R3 continue job");
    expect_reg(4'd8, 32'h280, "R3 count accumulates");

    // R5 + R7 key, close, outer, SHA-224
    wr(4'd9, 32'hB4);
    exp_q.push_back(3'd1); exp_q.push_back(3'd2); exp_q.push_back(3'd3);
    exp_q.push_back(3'd4); exp_q.push_back(3'd5);
    wr(4'd10, 32'd64);
    wait_idle("R5 key job");
    expect_reg(4'd8, 32'd128, "R5 count from 64");
    expect_reg(4'd9, 32'h04, "R5 R7 bits cleared");

    // R7 outer only with zero length
    wr(4'd8, 32'h1C5);
    wr(4'd9, 32'h80);
    exp_q.push_back(3'd5);
    wr(4'd10, 32'd0);
    wait_idle("R7 outer only");
    expect_reg(4'd8, 32'h1C0, "R7 count kept");
    expect_reg(4'd9, 32'h0, "R7 outer cleared");

    // R2 start with no work
    wr(4'd10, 32'd0);
    repeat (2) @(negedge clk);
    wait_idle("R2 empty job");
    expect_reg(4'd8, 32'h1C0, "R2 count untouched");

    // R3 wrap modulo 2^LW
    wr(4'd8, 32'hFC0);
    exp_q.push_back(3'd3);
    wr(4'd10, 32'd64);
    wait_idle("R3 wrap job");
    expect_reg(4'd8, 32'h0, "R3 count wraps");

    // R9 writes while busy ignored, SHA-1 constants
    wr(4'd9, 32'h0A);
    exp_q.push_back(3'd3); exp_q.push_back(3'd3); exp_q.push_back(3'd3);
    wr(4'd10, 32'd192);
    wr(4'd0, 32'hDEADBEEF);
    wr(4'd9, 32'hB0);
    wr(4'd10, 32'd64);
    wait_idle("R9 busy job");
    expect_reg(4'd0, 32'h67452301, "R9 digest write ignored");
    expect_reg(4'd4, 32'hc3d2e1f0, "R4 sha1 word4");
    expect_reg(4'd9, 32'h02, "R9 mode write ignored");
    expect_reg(4'd8, 32'hC0, "R9 count 192");
    expect_reg(4'd10, 32'h0, "R9 length write ignored");

    // R8 error
    wr(4'd9, 32'h0);
    wr(4'd10, 32'd100);
    check(cfg_err, "R8 error set", 32'(cfg_err), 32'h1);
    check(!busy, "R8 no start", 32'(busy), 32'h0);
    repeat (10) @(negedge clk);
    check(cfg_err, "R8 error sticky", 32'(cfg_err), 32'h1);
    expect_reg(4'd10, 32'h0, "R8 length kept");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule